// File: doc/BRIEF.md
# Polynomial arithmetic evaluator

This block takes one unsigned operand `a` and computes three functions of it at once: two linear ones, 2a+1 and 4a+3, and one quadratic, 8a²+10a+3. It is purely combinational. There is no clock, no register and no latch, so every output follows the present operand after the propagation delay of the logic. A surrounding datapath uses it wherever these odd-valued scalings of a small operand are needed together.

Each output is exactly as wide as its largest value requires, so no value can ever overflow. The operand width is a single parameter `N`. The output widths follow from it as N+1, N+2 and 2N+3 bits. The two linear results are wiring only: the operand is shifted left and ones are appended below it. The quadratic is formed as the product of the two linear results, (2a+1)(4a+3), which expands to 8a²+10a+3. The product width, (N+1)+(N+2), is then exactly the width the quadratic needs.

Top module: `poly_eval`

## Requirements
- R1: Output `x` is N+1 bits wide and equals 2a+1 for every unsigned N-bit value of `a`.
- R2: Output `y` is N+2 bits wide and equals 4a+3 for every unsigned N-bit value of `a`.
- R3: Output `z` is 2N+3 bits wide and equals 8a²+10a+3 for every unsigned N-bit value of `a`.
- R4: Bit 0 of `x` and bit 0 of `z` are always 1, and bits 1:0 of `y` are always binary 11.
- R5: At the largest operand (all ones), no output wraps and the most significant bit of each output is 1. For N=4 this gives x=31, y=63 and z=1953.
- R6: The outputs depend only on the present value of `a`. The same operand gives the same results whatever operand came before it and in whichever order operands are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Unsigned operand |
| x | output | N+1 | 2a+1 |
| y | output | N+2 | 4a+3 |
| z | output | 2N+3 | 8a²+10a+3 |

## Verification
The bench builds the block with N=4, which gives a 16-value operand space. That space is swept completely, first in ascending order and then in descending order. At each value the bench compares all three outputs against integer arithmetic. Because N is this small, the all-ones operand is covered, and with it the exact fit of every output width (z reaching 1953 in 11 bits). Repeating the sweep in reverse shows that no result depends on the operand that came before it.

// File: rtl/poly_eval_pkg.sv
// Package: shared width rules for the polynomial evaluator.
// Assumes: the operand is unsigned and at least one bit wide.
package poly_eval_pkg;

    // Width of 2a+1: one bit more than the operand.
    function automatic int lin1_width(input int n);
        return n + 1;
    endfunction

    // Width of 4a+3: two bits more than the operand.
    function automatic int lin2_width(input int n);
        return n + 2;
    endfunction

    // Width of the quadratic: the sum of both linear widths.
    function automatic int quad_width(input int n);
        return lin1_width(n) + lin2_width(n);
    endfunction

endpackage

// File: rtl/poly_shift_ones.sv
// Module: poly_shift_ones
// Purpose: forms a*2^K + (2^K - 1) by shifting the operand left by K and
// filling the vacated low bits with ones. No adder is needed.
// Assumes: K >= 1; the operand is unsigned.
module poly_shift_ones #(
    parameter int N = 4,
    parameter int K = 1,
    localparam int OW = N + K
) (
    input  logic [N-1:0]  a,
    output logic [OW-1:0] q
);

    // Concatenate the operand above a field of K ones.
    assign q = {a, {K{1'b1}}};

endmodule

// File: rtl/poly_mult.sv
// Module: poly_mult
// Purpose: unsigned shift-and-add multiplier. The product is exactly WA+WB
// bits wide, so it can never overflow.
// Assumes: both operands are unsigned; the logic is combinational only.
module poly_mult #(
    parameter int WA = 5,
    parameter int WB = 6,
    localparam int PW = WA + WB
) (
    input  logic [WA-1:0] a,
    input  logic [WB-1:0] b,
    output logic [PW-1:0] p
);

    logic [PW-1:0] a_ext;
    logic [PW-1:0] acc [0:WB];

    // Zero-extend the multiplicand to the product width.
    assign a_ext  = {{WB{1'b0}}, a};
    assign acc[0] = '0;

    // One partial product per multiplier bit, added into a ripple chain.
    for (genvar i = 0; i < WB; i++) begin : g_pp
        logic [PW-1:0] pp;
        // Gate the shifted multiplicand by multiplier bit i.
        assign pp         = {PW{b[i]}} & (a_ext << i);
        assign acc[i + 1] = acc[i] + pp;
    end

    // The last accumulator stage is the product.
    assign p = acc[WB];

endmodule

// File: rtl/poly_eval.sv
// Module: poly_eval (top)
// Purpose: evaluates 2a+1, 4a+3 and 8a^2+10a+3 for an unsigned N-bit
// operand. Each output has the minimum width that holds its largest value.
// Assumes: purely combinational use; there is no clock and no reset.
module poly_eval #(
    parameter int N = 4,
    localparam int XW = poly_eval_pkg::lin1_width(N),
    localparam int YW = poly_eval_pkg::lin2_width(N),
    localparam int ZW = poly_eval_pkg::quad_width(N)
) (
    input  logic [N-1:0]  a,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic [ZW-1:0] z
);

    // Linear term 2a+1: shift by one, append a one.
    poly_shift_ones #(.N(N), .K(1)) u_lin1 (
        .a (a),
        .q (x)
    );

    // Linear term 4a+3: shift by two, append two ones.
    poly_shift_ones #(.N(N), .K(2)) u_lin2 (
        .a (a),
        .q (y)
    );

    // Quadratic as the product (2a+1)(4a+3).
    poly_mult #(.WA(XW), .WB(YW)) u_quad (
        .a (x),
        .b (y),
        .p (z)
    );

endmodule

// File: rtl/poly_eval_chk.sv
// Module: poly_eval_chk
// Purpose: immediate assertions that relate the evaluator's outputs to one
// another and to the operand. Attached to poly_eval by bind.
// Assumes: checks apply only while the operand is a known value.
module poly_eval_chk #(
    parameter int N = 4,
    localparam int XW = N + 1,
    localparam int YW = N + 2,
    localparam int ZW = 2 * N + 3
) (
    input logic [N-1:0]  a,
    input logic [XW-1:0] x,
    input logic [YW-1:0] y,
    input logic [ZW-1:0] z
);

    longint ax, ay, az, aa;

    // Widen every value so the cross-checks cannot wrap.
    always_comb begin
        aa = longint'(a);
        ax = longint'(x);
        ay = longint'(y);
        az = longint'(z);
    end

    // Check output relations whenever the operand is known.
    always_comb begin
        if (!$isunknown(a)) begin
            // R1
            x_half_chk: assert ((ax - 1) / 2 == aa && ax[0])
                else $error("x does not encode 2a+1");
            // R2
            y_from_x_chk: assert (ay == 2 * ax + 1)
                else $error("y is not 2x+1");
            // R4
            low_bits_chk: assert (x[0] == 1'b1 && y[1:0] == 2'b11 && z[0] == 1'b1)
                else $error("fixed low bits wrong");
            // R3
            quad_form_chk: assert (az == 8 * aa * aa + 10 * aa + 3)
                else $error("z is not 8a^2+10a+3");
            // R5
            no_overflow_chk: assert (!(&a) || (x[XW-1] && y[YW-1] && z[ZW-1]))
                else $error("top output bit clear at maximum operand");
        end
    end

endmodule

bind poly_eval poly_eval_chk #(.N(N)) u_chk (
    .a (a),
    .x (x),
    .y (y),
    .z (z)
);

// File: tb/poly_eval_bench.sv
// Bench: exhaustive sweep of the N=4 evaluator, upward then downward,
// against integer arithmetic computed here.
module poly_eval_bench;

    localparam int N  = 4;
    localparam int XW = N + 1;
    localparam int YW = N + 2;
    localparam int ZW = 2 * N + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  a = '0;
    logic [XW-1:0] x;
    logic [YW-1:0] y;
    logic [ZW-1:0] z;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // 200 MHz pacing clock.
    always #2.5 clk = ~clk;

    poly_eval #(.N(N)) u_poly_eval (
        .a (a),
        .x (x),
        .y (y),
        .z (z)
    );

    // Compare one value and record the result.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (a=%0d)", req, act, exp, a);
        end
    endtask

    // Apply one operand at a falling edge and check all outputs before the next.
    task automatic apply(input int v);
        @(negedge clk);
        a = v[N-1:0];
        #1;
        check("R1 x", int'(x), 2 * v + 1);
        check("R2 y", int'(y), 4 * v + 3);
        check("R3 z", int'(z), 8 * v * v + 10 * v + 3);
        check("R4 low bits", int'({x[0], y[1:0], z[0]}), 15);
    endtask

    // Main stimulus: operand zero, upward sweep, corner checks, downward sweep.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Operand zero gives the smallest outputs (R1, R2, R3).
        apply(0);
        check("R1 x at zero", int'(x), 1);
        check("R3 z at zero", int'(z), 3);
        for (int v = 0; v < (1 << N); v++) apply(v);
        // R5: the maximum operand fits with every top bit set.
        apply((1 << N) - 1);
        check("R5 x max", int'(x), 31);
        check("R5 y max", int'(y), 63);
        check("R5 z max", int'(z), 1953);
        check("R5 top bits", int'({x[XW-1], y[YW-1], z[ZW-1]}), 7);
        // R6: reverse order and repeats give the same results.
        for (int v = (1 << N) - 1; v >= 0; v--) apply(v);
        apply(9);
        apply(3);
        apply(9);
        check("R6 z repeat", int'(z), 8 * 81 + 90 + 3);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule